// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the 13-bit program counter of a small 4-bit controller core and decides the next value every clock cycle. The fetch and decode stages outside tell it what the current instruction was through one-cycle strobes. The kinds of strobe are a plain step of one to three bytes, a short or long conditional branch, an accepted interrupt, a return from interrupt, and a preset of the stack pointer. Conditional branches follow the status flag that the core supplies. A short branch replaces only the low six bits of the incremented count, so its reach is limited to the current 64-byte window. A long branch replaces the low twelve bits.

An interrupt saves a frame on a 13-level hardware stack before the fixed vector is loaded. The frame holds the current PC and the carry, zero and status flags. A return from interrupt takes the frame back. It restores the PC and the three flags and sets the interrupt-enable output. Software can place the stack pointer at any level, so the first push may start anywhere in the ring.

Top module: `pc_sequencer`

## Requirements
- R1: After synchronous reset, `pc` is 000h, `sp` is 0, `int_en` is 0, `cf_out` and `zf_out` are 0 and `sf_out` is 1.
- R2: A step strobe adds `step_len` (1, 2 or 3) to `pc`, modulo 2000h. A length code of 0 leaves `pc` unchanged.
- R3: A short branch with `sf_in`=1 loads `pc` from bits 12:6 of (pc+1), with the 6-bit target in bits 5:0. With `sf_in`=0 it loads pc+1.
- R4: A long branch with `sf_in`=1 loads `pc` from bit 12 of (pc+2), with the 12-bit target in bits 11:0. With `sf_in`=0 it loads pc+2.
- R5: An interrupt strobe with a nonzero `irq_req` loads the vector of the lowest set bit. Bit 0 gives 002h, bit 1 gives 006h, bit 2 gives 008h, bit 3 gives 00Ah and bit 4 gives 00Ch. With `irq_req` all zero the strobe is ignored.
- R6: An accepted interrupt first moves `sp` down one level. It then stores the current `pc`, `cf_in`, `zf_in` and `sf_in` at the new level and clears `int_en`.
- R7: A return strobe reads the frame at `sp` and loads its PC into `pc` and its flags into `cf_out`/`zf_out`/`sf_out`. It sets `int_en` and moves `sp` up one level. Frames come back in last-in, first-out order.
- R8: `sp` stays in 0..12. A push at level 0 goes to level 12, and a pop at level 12 returns to level 0.
- R9: A stack-pointer load of a value from 0 to 12 sets `sp` to that value. Values of 13 or more leave `sp` unchanged. In any cycle with a stack-pointer load, `pc` and the stack contents do not change.
- R10: When several strobes are active together, only the highest takes effect. The order, from highest down, is stack-pointer load, accepted interrupt, return, long branch, short branch, step. With no strobe, `pc` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_valid | input | 1 | Sequential step strobe |
| step_len | input | 2 | Instruction length in bytes (1..3) |
| sbr_valid | input | 1 | Short branch strobe |
| sbr_target | input | 6 | Short branch low-bit target |
| lbr_valid | input | 1 | Long branch strobe |
| lbr_target | input | 12 | Long branch target |
| cf_in | input | 1 | Carry flag of the core |
| zf_in | input | 1 | Zero flag of the core |
| sf_in | input | 1 | Status flag; branch condition |
| irq_valid | input | 1 | Interrupt acceptance strobe |
| irq_req | input | 5 | Pending interrupt sources |
| reti_valid | input | 1 | Return from interrupt strobe |
| sp_load | input | 1 | Stack pointer preset strobe |
| sp_value | input | 4 | Stack pointer preset value |
| pc | output | 13 | Program counter |
| sp | output | 4 | Stack pointer level |
| cf_out | output | 1 | Restored carry flag |
| zf_out | output | 1 | Restored zero flag |
| sf_out | output | 1 | Restored status flag |
| int_en | output | 1 | Interrupt enable |

## Verification
The hardest cases to reach from the ports are those that depend on the upper end of the address space and on the ends of the stack ring. To reach bit 12 of the branch rules and the wrap of the counter, the bench takes a long branch near 0FFEh and steps across the 1000h boundary. It then takes another long branch whose incremented count carries into bit 12. To reach the ring ends, the bench presets the stack pointer to 0 or 12 before pushing or popping. It also presets it to a middle level before two nested interrupts, so that the last-in, first-out restore order can be seen together with distinct flag patterns.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int PCW   = 13;
    localparam int SBW   = 6;
    localparam int LBW   = 12;
    localparam int NIRQ  = 5;
    localparam int IRQW  = $clog2(NIRQ);

    typedef logic [PCW-1:0] pc_t;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
    } flags_t;

    typedef struct packed {
        pc_t    pc;
        flags_t fl;
    } frame_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_STEP,
        OP_SBR,
        OP_LBR,
        OP_IRQ,
        OP_RET,
        OP_SPLD
    } op_e;

    // Fixed entry address for each interrupt source index.
    function automatic pc_t irq_vector(input logic [IRQW-1:0] id);
        case (id)
            IRQW'(0): irq_vector = PCW'(12'h002);
            IRQW'(1): irq_vector = PCW'(12'h006);
            IRQW'(2): irq_vector = PCW'(12'h008);
            IRQW'(3): irq_vector = PCW'(12'h00A);
            IRQW'(4): irq_vector = PCW'(12'h00C);
            default:  irq_vector = '0;
        endcase
    endfunction

endpackage

// File: rtl/pcseq_irq_pick.sv
module pcseq_irq_pick #(
    parameter int N  = 5,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] id
);
    // Lowest set bit wins: scan downward so the last hit is the lowest index.
    always_comb begin
        any = |req;
        id  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) id = IW'(i);
        end
    end
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
    import pcseq_pkg::*;
(
    input  op_e             op,
    input  pc_t             pc_q,
    input  logic [1:0]      len,
    input  logic [SBW-1:0]  sbr_t,
    input  logic [LBW-1:0]  lbr_t,
    input  logic            sf,
    input  pc_t             vec,
    input  pc_t             ret_pc,
    output pc_t             pc_d
);
    pc_t pc1;
    pc_t pc2;
    pc_t pcs;

    always_comb begin
        pc1 = pc_q + PCW'(1);
        pc2 = pc_q + PCW'(2);
        pcs = pc_q + PCW'(len);
        unique case (op)
            OP_STEP: pc_d = pcs;
            OP_SBR:  pc_d = sf ? {pc1[PCW-1:SBW], sbr_t} : pc1;
            OP_LBR:  pc_d = sf ? {pc2[PCW-1:LBW], lbr_t} : pc2;
            OP_IRQ:  pc_d = vec;
            OP_RET:  pc_d = ret_pc;
            default: pc_d = pc_q;
        endcase
    end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack
    import pcseq_pkg::*;
#(
    parameter int DEPTH = 13,
    parameter int SPW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic           pop,
    input  logic           load,
    input  logic [SPW-1:0] load_val,
    input  frame_t         wr_frame,
    output frame_t         rd_frame,
    output logic [SPW-1:0] sp
);
    localparam logic [SPW-1:0] LAST = SPW'(DEPTH - 1);

    frame_t         mem [DEPTH];
    logic [SPW-1:0] sp_q;
    logic [SPW-1:0] sp_dn;
    logic [SPW-1:0] sp_up;

    assign sp_dn    = (sp_q == '0)   ? LAST : sp_q - SPW'(1);
    assign sp_up    = (sp_q == LAST) ? '0   : sp_q + SPW'(1);
    assign rd_frame = mem[sp_q];
    assign sp       = sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (load) begin
            if (load_val <= LAST) sp_q <= load_val;
        end else if (push) begin
            mem[sp_dn] <= wr_frame;
            sp_q       <= sp_dn;
        end else if (pop) begin
            sp_q <= sp_up;
        end
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int DEPTH = 13,
    parameter int SPW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_valid,
    input  logic [1:0]           step_len,
    input  logic                 sbr_valid,
    input  logic [SBW-1:0]       sbr_target,
    input  logic                 lbr_valid,
    input  logic [LBW-1:0]       lbr_target,
    input  logic                 cf_in,
    input  logic                 zf_in,
    input  logic                 sf_in,
    input  logic                 irq_valid,
    input  logic [NIRQ-1:0]      irq_req,
    input  logic                 reti_valid,
    input  logic                 sp_load,
    input  logic [SPW-1:0]       sp_value,
    output logic [PCW-1:0]       pc,
    output logic [SPW-1:0]       sp,
    output logic                 cf_out,
    output logic                 zf_out,
    output logic                 sf_out,
    output logic                 int_en
);
    op_e              op;
    logic             irq_any;
    logic [IRQW-1:0]  irq_id;
    pc_t              pc_q;
    pc_t              pc_d;
    flags_t           fl_q;
    logic             ie_q;
    frame_t           push_frame;
    frame_t           top_frame;

    pcseq_irq_pick #(.N(NIRQ), .IW(IRQW)) u_pick (
        .req (irq_req),
        .any (irq_any),
        .id  (irq_id)
    );

    // Strobe priority: SP preset, interrupt, return, long, short, step.
    always_comb begin
        if (sp_load)                   op = OP_SPLD;
        else if (irq_valid && irq_any) op = OP_IRQ;
        else if (reti_valid)           op = OP_RET;
        else if (lbr_valid)            op = OP_LBR;
        else if (sbr_valid)            op = OP_SBR;
        else if (step_valid)           op = OP_STEP;
        else                           op = OP_HOLD;
    end

    assign push_frame = '{pc: pc_q, fl: '{cf: cf_in, zf: zf_in, sf: sf_in}};

    pcseq_stack #(.DEPTH(DEPTH), .SPW(SPW)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (op == OP_IRQ),
        .pop      (op == OP_RET),
        .load     (op == OP_SPLD),
        .load_val (sp_value),
        .wr_frame (push_frame),
        .rd_frame (top_frame),
        .sp       (sp)
    );

    pcseq_next u_next (
        .op     (op),
        .pc_q   (pc_q),
        .len    (step_len),
        .sbr_t  (sbr_target),
        .lbr_t  (lbr_target),
        .sf     (sf_in),
        .vec    (irq_vector(irq_id)),
        .ret_pc (top_frame.pc),
        .pc_d   (pc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            fl_q <= '{cf: 1'b0, zf: 1'b0, sf: 1'b1};
            ie_q <= 1'b0;
        end else begin
            pc_q <= pc_d;
            if (op == OP_IRQ) begin
                ie_q <= 1'b0;
            end else if (op == OP_RET) begin
                ie_q <= 1'b1;
                fl_q <= top_frame.fl;
            end
        end
    end

    assign pc     = pc_q;
    assign cf_out = fl_q.cf;
    assign zf_out = fl_q.zf;
    assign sf_out = fl_q.sf;
    assign int_en = ie_q;
endmodule

// File: rtl/pcseq_check.sv
module pcseq_check #(
    parameter int DEPTH = 13,
    parameter int SPW   = $clog2(DEPTH)
) (
    input logic           clk,
    input logic           rst,
    input logic           step_valid,
    input logic           sbr_valid,
    input logic           lbr_valid,
    input logic           irq_valid,
    input logic [4:0]     irq_req,
    input logic           reti_valid,
    input logic           sp_load,
    input logic [12:0]    pc,
    input logic [SPW-1:0] sp,
    input logic           cf_out,
    input logic           zf_out,
    input logic           sf_out,
    input logic           int_en
);
    localparam logic [SPW-1:0] LAST = SPW'(DEPTH - 1);

    logic take_irq;
    logic take_ret;
    logic idle;

    assign take_irq = !sp_load && irq_valid && (irq_req != '0);
    assign take_ret = !sp_load && !take_irq && reti_valid;
    assign idle     = !sp_load && !take_irq && !reti_valid && !lbr_valid
                      && !sbr_valid && !step_valid;

    a_r8_sp_in_range: assert property (@(posedge clk) disable iff (rst)
        sp <= LAST);

    a_r5_vector_loaded: assert property (@(posedge clk) disable iff (rst)
        take_irq |=> (pc[0] == 1'b0 && pc >= 13'h002 && pc <= 13'h00C));

    a_r6_push_level: assert property (@(posedge clk) disable iff (rst)
        take_irq |=> (!int_en &&
                      sp == (($past(sp) == '0) ? LAST : $past(sp) - SPW'(1))));

    a_r7_pop_level: assert property (@(posedge clk) disable iff (rst)
        take_ret |=> (int_en &&
                      sp == (($past(sp) == LAST) ? '0 : $past(sp) + SPW'(1))));

    a_r7_flags_only_on_return: assert property (@(posedge clk) disable iff (rst)
        !take_ret |=> $stable({cf_out, zf_out, sf_out}));

    a_r9_load_holds_pc: assert property (@(posedge clk) disable iff (rst)
        sp_load |=> $stable(pc));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        idle |=> ($stable(pc) && $stable(sp) && $stable(int_en)));
endmodule

bind pc_sequencer pcseq_check u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_valid (step_valid),
    .sbr_valid  (sbr_valid),
    .lbr_valid  (lbr_valid),
    .irq_valid  (irq_valid),
    .irq_req    (irq_req),
    .reti_valid (reti_valid),
    .sp_load    (sp_load),
    .pc         (pc),
    .sp         (sp),
    .cf_out     (cf_out),
    .zf_out     (zf_out),
    .sf_out     (sf_out),
    .int_en     (int_en)
);

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_valid, sbr_valid, lbr_valid, irq_valid, reti_valid, sp_load;
    logic [1:0]  step_len;
    logic [5:0]  sbr_target;
    logic [11:0] lbr_target;
    logic        cf_in, zf_in, sf_in;
    logic [4:0]  irq_req;
    logic [3:0]  sp_value;
    logic [12:0] pc;
    logic [3:0]  sp;
    logic        cf_out, zf_out, sf_out, int_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pc_sequencer uut (
        .clk(clk), .rst(rst),
        .step_valid(step_valid), .step_len(step_len),
        .sbr_valid(sbr_valid), .sbr_target(sbr_target),
        .lbr_valid(lbr_valid), .lbr_target(lbr_target),
        .cf_in(cf_in), .zf_in(zf_in), .sf_in(sf_in),
        .irq_valid(irq_valid), .irq_req(irq_req),
        .reti_valid(reti_valid), .sp_load(sp_load), .sp_value(sp_value),
        .pc(pc), .sp(sp), .cf_out(cf_out), .zf_out(zf_out), .sf_out(sf_out),
        .int_en(int_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        step_valid = 0; sbr_valid = 0; lbr_valid = 0; irq_valid = 0;
        reti_valid = 0; sp_load = 0; step_len = 0; sbr_target = 0;
        lbr_target = 0; cf_in = 0; zf_in = 0; sf_in = 0; irq_req = 0; sp_value = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        clear_in(); rst = 1; tick(); tick(); rst = 0;
    endtask

    task automatic go_step(input logic [1:0] n);
        step_valid = 1; step_len = n; tick(); clear_in();
    endtask
    task automatic go_lbr(input logic [11:0] t, input logic s);
        lbr_valid = 1; lbr_target = t; sf_in = s; tick(); clear_in();
    endtask
    task automatic go_sbr(input logic [5:0] t, input logic s);
        sbr_valid = 1; sbr_target = t; sf_in = s; tick(); clear_in();
    endtask
    task automatic go_irq(input logic [4:0] r, input logic c, input logic z, input logic s);
        irq_valid = 1; irq_req = r; cf_in = c; zf_in = z; sf_in = s; tick(); clear_in();
    endtask
    task automatic go_reti(input logic c, input logic z, input logic s);
        reti_valid = 1; cf_in = c; zf_in = z; sf_in = s; tick(); clear_in();
    endtask
    task automatic go_spld(input logic [3:0] v);
        sp_load = 1; sp_value = v; tick(); clear_in();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pc", pc, 13'h000);
        chk("R1 sp", sp, 4'd0);
        chk("R1 int_en", int_en, 1'b0);
        chk("R1 flags", {cf_out, zf_out, sf_out}, 3'b001);
    endtask

    task automatic t_step();
        do_reset();
        go_step(2'd1); chk("R2 step+1", pc, 13'h001);
        go_step(2'd2); chk("R2 step+2", pc, 13'h003);
        go_step(2'd3); chk("R2 step+3", pc, 13'h006);
        go_step(2'd0); chk("R2 len0 holds", pc, 13'h006);
        tick();        chk("R10 idle holds", pc, 13'h006);
    endtask

    task automatic t_long_and_wrap();
        do_reset();
        go_lbr(12'h123, 1'b0); chk("R4 long not taken", pc, 13'h002);
        go_lbr(12'hFFE, 1'b1); chk("R4 long taken", pc, 13'h0FFE);
        go_step(2'd3);         chk("R2 step across 1000h", pc, 13'h1001);
        go_lbr(12'hFFF, 1'b1); chk("R4 bit12 kept", pc, 13'h1FFF);
        go_step(2'd1);         chk("R2 wrap to 0", pc, 13'h0000);
    endtask

    task automatic t_short();
        do_reset();
        go_lbr(12'h07F, 1'b1);
        go_sbr(6'h15, 1'b1);   chk("R3 short taken uses pc+1 page", pc, 13'h095);
        go_sbr(6'h3A, 1'b0);   chk("R3 short not taken", pc, 13'h096);
        go_lbr(12'h03F, 1'b1);
        go_sbr(6'h00, 1'b1);   chk("R3 short at page edge", pc, 13'h040);
    endtask

    task automatic t_vectors();
        logic [12:0] vec [5];
        vec[0] = 13'h002; vec[1] = 13'h006; vec[2] = 13'h008;
        vec[3] = 13'h00A; vec[4] = 13'h00C;
        for (int i = 0; i < 5; i++) begin
            do_reset();
            go_lbr(12'h123, 1'b1);
            go_irq(5'(1 << i), 1'b0, 1'b0, 1'b0);
            chk($sformatf("R5 vector of source %0d", i), pc, vec[i]);
        end
        do_reset();
        go_irq(5'b00000, 1'b1, 1'b1, 1'b1);
        chk("R5 empty request ignored pc", pc, 13'h000);
        chk("R5 empty request ignored sp", sp, 4'd0);
    endtask

    task automatic t_irq_return();
        do_reset();
        go_lbr(12'h123, 1'b1);
        go_irq(5'b10100, 1'b1, 1'b0, 1'b1);
        chk("R5 lowest source wins", pc, 13'h008);
        chk("R8 push from 0 wraps to 12", sp, 4'd12);
        chk("R6 int_en cleared", int_en, 1'b0);
        go_step(2'd1);
        go_reti(1'b0, 1'b1, 1'b0);
        chk("R7 pc restored", pc, 13'h123);
        chk("R7 flags restored", {cf_out, zf_out, sf_out}, 3'b101);
        chk("R7 int_en set", int_en, 1'b1);
        chk("R8 pop from 12 wraps to 0", sp, 4'd0);
    endtask

    task automatic t_nested();
        do_reset();
        go_spld(4'd5);
        go_lbr(12'h200, 1'b1);
        go_irq(5'b00001, 1'b0, 1'b1, 1'b0);
        chk("R6 first push level", sp, 4'd4);
        go_step(2'd2);
        go_irq(5'b10000, 1'b1, 1'b1, 1'b1);
        chk("R6 second push level", sp, 4'd3);
        chk("R5 inner vector", pc, 13'h00C);
        go_reti(1'b0, 1'b0, 1'b0);
        chk("R7 inner return pc", pc, 13'h004);
        chk("R7 inner return flags", {cf_out, zf_out, sf_out}, 3'b111);
        go_reti(1'b1, 1'b1, 1'b1);
        chk("R7 outer return pc", pc, 13'h200);
        chk("R7 outer return flags", {cf_out, zf_out, sf_out}, 3'b010);
        chk("R7 outer return level", sp, 4'd5);
    endtask

    task automatic t_sp_load();
        do_reset();
        go_spld(4'd12); chk("R9 load 12", sp, 4'd12);
        go_spld(4'd13); chk("R9 load 13 ignored", sp, 4'd12);
        go_spld(4'd15); chk("R9 load 15 ignored", sp, 4'd12);
        go_reti(1'b0, 1'b0, 1'b0);
        chk("R8 pop at 12 wraps", sp, 4'd0);
        go_lbr(12'h0A0, 1'b1);
        sp_load = 1; sp_value = 4'd7; step_valid = 1; step_len = 2'd3;
        irq_valid = 1; irq_req = 5'b00001; tick(); clear_in();
        chk("R9 load wins sp", sp, 4'd7);
        chk("R9 pc held during load", pc, 13'h0A0);
        chk("R9 int_en untouched", int_en, 1'b1);
    endtask

    task automatic t_priority();
        do_reset();
        lbr_valid = 1; lbr_target = 12'h300; sbr_valid = 1; sbr_target = 6'h11;
        step_valid = 1; step_len = 2'd3; sf_in = 1; tick(); clear_in();
        chk("R10 long over short and step", pc, 13'h300);
        sbr_valid = 1; sbr_target = 6'h05; step_valid = 1; step_len = 2'd2;
        sf_in = 1; tick(); clear_in();
        chk("R10 short over step", pc, 13'h305);
        irq_valid = 1; irq_req = 5'b00000; step_valid = 1; step_len = 2'd1;
        tick(); clear_in();
        chk("R5 empty irq falls through to step", pc, 13'h306);
        irq_valid = 1; irq_req = 5'b00010; reti_valid = 1; tick(); clear_in();
        chk("R10 interrupt over return pc", pc, 13'h006);
        chk("R10 interrupt over return sp", sp, 4'd12);
        reti_valid = 1; lbr_valid = 1; lbr_target = 12'h777; sf_in = 1;
        tick(); clear_in();
        chk("R10 return over long pc", pc, 13'h306);
        chk("R10 return over long sp", sp, 4'd0);
    endtask

    initial begin
        clear_in();
        t_reset();
        t_step();
        t_long_and_wrap();
        t_short();
        t_vectors();
        t_irq_return();
        t_nested();
        t_sp_load();
        t_priority();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule